// File: doc/BRIEF.md
# Four-Lane 7:1 Serial Link Transmitter

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane. Every lane carries seven bits in each pixel period. The whole block runs on a single bit clock at seven times the pixel rate. The pixel clock arrives phase-aligned to the bit clock and is treated as a level that is sampled on every bit-clock edge. A select input decides whether a word is taken on the rising or the falling edge of the pixel clock.

Each word is fully transmitted in the pixel period that follows its capture, one whole word at a time. Input bit positions are scattered over lanes and bit slots by a fixed table. The clock lane is high for the first four slots of each period and low for the last three, so its rising edge marks slot 0.

A shutdown input blanks every output at once. After reset, or after shutdown is released, the outputs stay blanked and the valid indication stays low until a programmable number of capture events (`LOCK_PIX`) has passed. This stands in for the settling time of a lock loop.

Top module: `serlink7_tx`

## Requirements
- R1: With `edge_sel` = 0, `pix_data` is captured at the bit-clock edge where `pix_clk` is first seen high after having been seen low. Reset clears the edge detector's history to low.
- R2: With `edge_sel` = 1, `pix_data` is captured at the bit-clock edge where `pix_clk` is first seen low after having been seen high.
- R3: Lane bit `lane_o[L]` in slot S carries word bit T[4*S+L], where T = 1,9,20,5, 0,8,19,27, 7,18,26,23, 6,15,25,17, 4,14,24,16, 3,13,22,11, 2,12,21,10 (slot 0 first, lanes 0 to 3 within a slot).
- R4: While valid, `clk_lane_o` is 1 in slots 0 to 3 and 0 in slots 4 to 6. Slot 0 is the first bit-clock cycle after a capture edge.
- R5: The word captured at capture event N goes out over the seven bit-clock cycles after capture event N+1, in slots 0 to 6.
- R6: While `rst` is high, and in the cycle after it, `tx_valid_o`, `lane_o` and `clk_lane_o` are all 0.
- R7: `tx_valid_o` rises at the LOCK_PIX-th capture event after reset or after shutdown is released. While it is low, `lane_o` and `clk_lane_o` are 0.
- R8: While `shutdown` is high, `tx_valid_o`, `lane_o` and `clk_lane_o` are 0 in the same cycle, and the lock count restarts from zero.
- R9: `tx_valid_o` only rises at a word boundary, with slot 0 on the outputs, so no word is sent in part when lock is gained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled as a level |
| edge_sel | input | 1 | 0: capture on the rising pixel edge, 1: on the falling edge |
| shutdown | input | 1 | Blanks all outputs and restarts the lock interval |
| pix_data | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes, one bit per bit-clock cycle each |
| clk_lane_o | output | 1 | Forwarded clock lane, pattern 1111000 |
| tx_valid_o | output | 1 | Output-enable indication; outputs carry data only when high |

## Verification
The assertions check on every cycle that the outputs are blanked while not valid, and that the capture register holds between capture events. They also check that every clock-lane rising edge and every gain of valid comes right after a capture event, and that valid is low in the cycle shutdown is released. Only the bench scenarios show that the bit scrambling is correct and that words arrive one period late in both edge modes. They also show that the lock interval lasts exactly LOCK_PIX events, and that a framing receiver locked to the clock lane rebuilds each applied word.

// File: rtl/serlink7_pkg.sv
package serlink7_pkg;
    localparam int WORD_W     = 28;
    localparam int NLANES     = 4;
    localparam int NSLOTS     = 7;
    localparam int CLK_HI     = 4;
    localparam int SLOT_W     = $clog2(NSLOTS);
    localparam int IDX_W      = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // One bit time of the link: four data lanes plus the forwarded clock
    typedef struct packed {
        logic [NLANES-1:0] data;
        logic              fclk;
    } sym_t;

    // Scramble table, indexed slot*NLANES+lane; order is behaviour (R3)
    localparam logic [IDX_W-1:0] SCRAMBLE [NSLOTS*NLANES] = '{
        5'd1,  5'd9,  5'd20, 5'd5,
        5'd0,  5'd8,  5'd19, 5'd27,
        5'd7,  5'd18, 5'd26, 5'd23,
        5'd6,  5'd15, 5'd25, 5'd17,
        5'd4,  5'd14, 5'd24, 5'd16,
        5'd3,  5'd13, 5'd22, 5'd11,
        5'd2,  5'd12, 5'd21, 5'd10
    };

    function automatic logic [IDX_W-1:0] src_bit(slot_t s, int lane);
        int k;
        k = int'(s) * NLANES + lane;
        if (k >= NSLOTS*NLANES) k = 0;
        return SCRAMBLE[k];
    endfunction
endpackage

// File: rtl/serlink7_capture.sv
module serlink7_capture import serlink7_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  pix_clk,
    input  logic  edge_sel,
    input  word_t pix_data,
    output logic  cap_evt,
    output word_t cap_word
);
    logic pix_q;

    // R1 rising-edge capture, R2 falling-edge capture
    always_comb begin
        if (edge_sel) cap_evt = pix_q & ~pix_clk;
        else          cap_evt = pix_clk & ~pix_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q    <= 1'b0;
            cap_word <= '0;
        end else begin
            pix_q <= pix_clk;
            if (cap_evt) cap_word <= pix_data;
        end
    end
endmodule

// File: rtl/serlink7_lock.sv
module serlink7_lock #(
    parameter int LOCK_PIX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic shutdown,
    input  logic cap_evt,
    output logic locked
);
    localparam int CW = $clog2(LOCK_PIX + 1);
    logic [CW-1:0] cnt;

    // R7 lock interval counted in capture events; R8 restart on shutdown
    always_ff @(posedge clk) begin
        if (rst || shutdown) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (cap_evt && !locked) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(LOCK_PIX - 1)) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/serlink7_shift.sv
module serlink7_shift import serlink7_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_evt,
    input  word_t cap_word,
    output slot_t slot,
    output sym_t  sym
);
    localparam slot_t SLOT_LAST = slot_t'(NSLOTS - 1);
    word_t word_q;

    // R5: the previously captured word is loaded at the next capture edge
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            slot   <= '0;
        end else if (cap_evt) begin
            word_q <= cap_word;
            slot   <= '0;
        end else begin
            slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
        end
    end

    // R3: one scrambled bit per lane
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        always_comb sym.data[l] = word_q[src_bit(slot, l)];
    end

    // R4: clock lane high for the first CLK_HI slots
    always_comb sym.fclk = (slot < slot_t'(CLK_HI));
endmodule

// File: rtl/serlink7_tx.sv
module serlink7_tx import serlink7_pkg::*; #(
    parameter int LOCK_PIX = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              edge_sel,
    input  logic              shutdown,
    input  logic [WORD_W-1:0] pix_data,
    output logic [NLANES-1:0] lane_o,
    output logic              clk_lane_o,
    output logic              tx_valid_o
);
    logic  cap_evt;
    word_t cap_word;
    logic  locked;
    slot_t slot;
    sym_t  sym;

    serlink7_capture u_cap (
        .clk(clk), .rst(rst), .pix_clk(pix_clk), .edge_sel(edge_sel),
        .pix_data(pix_data), .cap_evt(cap_evt), .cap_word(cap_word)
    );

    serlink7_lock #(.LOCK_PIX(LOCK_PIX)) u_lock (
        .clk(clk), .rst(rst), .shutdown(shutdown),
        .cap_evt(cap_evt), .locked(locked)
    );

    serlink7_shift u_shift (
        .clk(clk), .rst(rst), .cap_evt(cap_evt), .cap_word(cap_word),
        .slot(slot), .sym(sym)
    );

    // R6 R7 R8: blank everything unless locked and not shut down
    always_comb begin
        tx_valid_o = locked & ~shutdown;
        lane_o     = sym.data & {NLANES{tx_valid_o}};
        clk_lane_o = sym.fclk & tx_valid_o;
    end
endmodule

// File: rtl/serlink7_tx_chk.sv
module serlink7_tx_chk import serlink7_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              shutdown,
    input logic              cap_evt,
    input logic [WORD_W-1:0] cap_word,
    input logic [NLANES-1:0] lane_o,
    input logic              clk_lane_o,
    input logic              tx_valid_o
);
    p_capture_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(cap_word));

    p_clk_rise_after_capture_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_lane_o) |-> $past(cap_evt));

    p_blank_when_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_o |-> (lane_o == '0) && !clk_lane_o);

    p_relock_after_shutdown_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(shutdown) |-> !tx_valid_o);

    p_valid_on_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid_o) |-> $past(cap_evt));
endmodule

bind serlink7_tx serlink7_tx_chk u_chk (
    .clk(clk), .rst(rst), .shutdown(shutdown), .cap_evt(cap_evt),
    .cap_word(cap_word), .lane_o(lane_o), .clk_lane_o(clk_lane_o),
    .tx_valid_o(tx_valid_o)
);

// File: tb/serlink7_tx_bench.sv
`timescale 1ns/100ps
module serlink7_tx_bench;
    localparam int LOCK = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk = 1'b0;
    logic        edge_sel = 1'b0;
    logic        shutdown = 1'b0;
    logic [27:0] pix_data = '0;
    logic [3:0]  lane_o;
    logic        clk_lane_o;
    logic        tx_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    serlink7_tx #(.LOCK_PIX(LOCK)) u_serlink7_tx (
        .clk(clk), .rst(rst), .pix_clk(pix_clk), .edge_sel(edge_sel),
        .shutdown(shutdown), .pix_data(pix_data), .lane_o(lane_o),
        .clk_lane_o(clk_lane_o), .tx_valid_o(tx_valid_o)
    );

    always #2.5 clk = ~clk;

    function automatic int src(int s, int l);
        int t[28] = '{1,9,20,5, 0,8,19,27, 7,18,26,23, 6,15,25,17,
                      4,14,24,16, 3,13,22,11, 2,12,21,10};
        return t[s*4 + l];
    endfunction

    function automatic logic [3:0] lane_bits(logic [27:0] w, int s);
        logic [3:0] r;
        for (int l = 0; l < 4; l++) r[l] = w[src(s, l)];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // stimulus generator: pixel clock 4 high / 3 low, data changes mid-period
    int ph = 6;
    int pat_mode = 0;
    int pat_k = 0;
    always @(negedge clk) begin
        ph = (ph == 6) ? 0 : ph + 1;
        pix_clk <= (ph < 4);
        if (ph == 2) begin
            pat_k++;
            case (pat_mode)
                0: pix_data <= 28'($urandom());
                1: pix_data <= 28'(1) << (pat_k % 28);
                2: pix_data <= (pat_k % 2) ? 28'hFFFFFFF : 28'h0;
                default: pix_data <= (pat_k % 2) ? 28'h5555555 : 28'hAAAAAAA;
            endcase
        end
    end

    // behavioural reference, advanced on each bit-clock edge
    bit          pprev, mval;
    int          lcnt, mslot;
    logic [27:0] last_cap, exp_word;
    bit          prev_valid, prev_clk;
    int          dslot = -1;
    logic [27:0] rec;

    always @(posedge clk) begin
        bit ev, ev_v, ec;
        logic [3:0] el;
        string ltag, vtag;
        if (rst) begin
            pprev = 0; mval = 0; lcnt = 0; mslot = 0;
            last_cap = '0; exp_word = '0;
        end else begin
            ev = edge_sel ? (!pix_clk && pprev) : (pix_clk && !pprev);
            pprev = pix_clk;
            if (shutdown) begin
                lcnt = 0; mval = 0;
            end else if (ev && !mval) begin
                lcnt++;
                if (lcnt == LOCK) mval = 1;
            end
            if (ev) begin
                exp_word = last_cap; last_cap = pix_data; mslot = 0;
            end else begin
                mslot = (mslot + 1) % 7;
            end
        end
        #1;
        ev_v = mval && !shutdown && !rst;
        el   = ev_v ? lane_bits(exp_word, mslot) : 4'h0;
        ec   = ev_v && (mslot < 4);
        vtag = rst ? "R6 valid" : (shutdown ? "R8 valid" : "R7 valid");
        ltag = edge_sel ? "R2 R3 R5 lanes" : "R1 R3 R5 lanes";
        check(tx_valid_o == ev_v, vtag, 32'(tx_valid_o), 32'(ev_v));
        check(lane_o == el, ltag, 32'(lane_o), 32'(el));
        check(clk_lane_o == ec, "R4 clock lane", 32'(clk_lane_o), 32'(ec));
        if (tx_valid_o && !prev_valid)
            check(clk_lane_o == 1'b1, "R9 valid at word start", 32'(clk_lane_o), 32'd1);
        // framing receiver driven by the clock lane alone
        if (tx_valid_o && clk_lane_o && !prev_clk) begin
            dslot = 0; rec = '0;
        end
        if (!tx_valid_o) dslot = -1;
        if (dslot >= 0) begin
            for (int l = 0; l < 4; l++) rec[src(dslot, l)] = lane_o[l];
            if (dslot == 6) begin
                check(rec == exp_word, "R5 recovered word", 32'(rec), 32'(exp_word));
                dslot = -1;
            end else begin
                dslot++;
            end
        end
        prev_valid = tx_valid_o;
        prev_clk   = clk_lane_o;
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // reset phase with rising-edge capture (R6)
        wait_cycles(10);
        rst <= 1'b0;
        for (int m = 0; m < 4; m++) begin
            pat_mode = m;
            wait_cycles(140);
        end
        // shutdown in mid-word, then relock (R8, R7, R9)
        wait_cycles(3);
        shutdown <= 1'b1;
        wait_cycles(20);
        shutdown <= 1'b0;
        pat_mode = 0;
        wait_cycles(120);
        // falling-edge capture after a fresh reset (R2)
        rst <= 1'b1;
        edge_sel <= 1'b1;
        wait_cycles(10);
        rst <= 1'b0;
        for (int m = 0; m < 4; m++) begin
            pat_mode = m;
            wait_cycles(120);
        end
        wait_cycles(5);
        shutdown <= 1'b1;
        wait_cycles(9);
        shutdown <= 1'b0;
        wait_cycles(100);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule